// File: doc/BRIEF.md
# Circular Buffer DMA Source Sequencer

This block paces one DMA channel that streams 32-bit words from a circular memory buffer into a single peripheral data register. Each time the peripheral asks for data, the block runs a short burst, called a minor loop, of word transfers. For each transfer it issues a strobe with a source address, a destination address and a transfer size. The source address steps by one word per transfer. It wraps inside a buffer of 2^MOD_BITS bytes by keeping the upper address bits fixed and letting only the low bits count. The destination never moves.

Minor loops are counted toward a major loop. When a major loop completes, the block pulses a completion interrupt. In the same cycle it advances a byte position that tells software how far playback has moved through the buffer. The major counter then reloads, so the channel keeps going with no further setup. The base address, the destination and the loop sizes are static; the memory bus itself is outside this block.

Top module: `dma_circ_src_seq`

## Requirements
- R1: After reset, `xfer_valid` and `irq` are low, `position` is 0 and the first transfer uses `src_base` as its source address.
- R2: A minor loop is accepted only on a clock edge where `req` is high and no minor loop is active. Its MINOR_XFERS strobes then appear on consecutive cycles, starting the cycle after acceptance.
- R3: `req` has no effect while a minor loop is active: the loop neither lengthens nor restarts.
- R4: Each transfer's source address is the previous one plus 4 within the low MOD_BITS bits, modulo 2^MOD_BITS. The bits above MOD_BITS stay equal to those of `src_base`.
- R5: On every strobe, `xfer_dst` equals `dst_addr` and `xfer_size` is 2'b10, the code for 4-byte words on both sides.
- R6: After the last strobe of the MAJOR_LOOPS-th minor loop, `irq` is high for exactly one cycle, the cycle right after that strobe.
- R7: After a major loop the minor counter reloads and later requests start a new major loop with no other input.
- R8: `position` changes only in the cycle `irq` is high. It then becomes old + 4·MINOR_XFERS·MAJOR_LOOPS, minus 2^MOD_BITS if that sum reaches or exceeds 2^MOD_BITS.
- R9: After the last strobe of a minor loop there is at least one cycle without a strobe before the next minor loop starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_base | input | 32 | Static start address inside the circular buffer (word aligned) |
| dst_addr | input | 32 | Static peripheral data-register address |
| req | input | 1 | Peripheral service request |
| xfer_valid | output | 1 | Transfer strobe, one word per cycle |
| xfer_src | output | 32 | Source address of the current transfer |
| xfer_dst | output | 32 | Destination address of the current transfer |
| xfer_size | output | 2 | Transfer size code (2'b10 = 32 bits) |
| irq | output | 1 | One-cycle major-loop completion pulse |
| position | output | MOD_BITS | Byte position in the buffer |

## Verification
Two events can land on the same edge: the end of a major loop, and the wrap of the source address and of the position past the buffer boundary. The bench uses a reduced setup of a 64-byte buffer, 4 transfers per minor loop and 3 minor loops per major loop. With that setup, every fourth major completion lands exactly on the buffer boundary, so the address wrap and the position wrap must both appear in the cycle of the interrupt. The request is also held high through the completion. This checks that the next minor loop is accepted at the end of the interrupt cycle without being lost or doubled. A behavioural model updated on every clock judges each strobe, address, interrupt and position value.

// File: rtl/dma_circ_pkg.sv
package dma_circ_pkg;
   typedef logic [31:0] addr_t;

   localparam int unsigned WORD_BYTES = 4;
   localparam logic [1:0]  SIZE_32BIT = 2'b10;

   // step an address inside a 2^mod_bits window, keeping upper bits
   function automatic addr_t mod_advance(addr_t a, int unsigned mod_bits, int unsigned step);
      addr_t mask;
      mask = (mod_bits >= 32) ? '1 : ((32'd1 << mod_bits) - 32'd1);
      return (a & ~mask) | ((a + addr_t'(step)) & mask);
   endfunction
endpackage

// File: rtl/dma_loop_counter.sv
module dma_loop_counter #(
   parameter int unsigned LIMIT = 16,
   localparam int unsigned CW = $clog2(LIMIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [CW-1:0] count,
   output logic          last
);
   if (LIMIT < 2) begin : g_bad_limit
      $error("dma_loop_counter: LIMIT must be at least 2");
   end

   localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

   assign last = (count == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           count <= '0;
      else if (step && last) count <= '0;
      else if (step)         count <= count + CW'(1);
   end

   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= TOP);
endmodule

// File: rtl/dma_src_offset.sv
module dma_src_offset #(
   parameter int unsigned MOD_BITS = 17
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  advance,
   input  dma_circ_pkg::addr_t   base,
   output dma_circ_pkg::addr_t   addr
);
   import dma_circ_pkg::*;

   if (MOD_BITS >= 32) begin : g_flat
      addr_t off;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       off <= '0;
         else if (advance) off <= off + addr_t'(WORD_BYTES);
      end
      assign addr = base + off;
   end else begin : g_modulo
      localparam addr_t MASK = (32'd1 << MOD_BITS) - 32'd1;
      logic [MOD_BITS-1:0] off;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       off <= '0;
         else if (advance) off <= off + MOD_BITS'(WORD_BYTES);
      end
      assign addr = (base & ~MASK) | ((base + addr_t'(off)) & MASK);
   end
endmodule

// File: rtl/dma_pos_accum.sv
module dma_pos_accum #(
   parameter int unsigned MOD_BITS    = 17,
   parameter int unsigned MAJOR_BYTES = 32768
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                add,
   output logic [MOD_BITS-1:0] pos
);
   localparam int unsigned SW = MOD_BITS + 1;
   localparam logic [SW-1:0] BUF  = SW'(1) << MOD_BITS;
   localparam logic [SW-1:0] INCR = SW'(MAJOR_BYTES);

   if (MAJOR_BYTES > (64'd1 << MOD_BITS)) begin : g_bad_incr
      $error("dma_pos_accum: major loop larger than buffer");
   end

   logic [SW-1:0] sum;
   assign sum = {1'b0, pos} + INCR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pos <= '0;
      else if (add) pos <= (sum >= BUF) ? MOD_BITS'(sum - BUF) : MOD_BITS'(sum);
   end

   assert_pos_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !add |=> $stable(pos));
endmodule

// File: rtl/dma_circ_src_seq.sv
module dma_circ_src_seq #(
   parameter int unsigned MINOR_XFERS = 16,
   parameter int unsigned MAJOR_LOOPS = 512,
   parameter int unsigned MOD_BITS    = 17
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [31:0]         src_base,
   input  logic [31:0]         dst_addr,
   input  logic                req,
   output logic                xfer_valid,
   output logic [31:0]         xfer_src,
   output logic [31:0]         xfer_dst,
   output logic [1:0]          xfer_size,
   output logic                irq,
   output logic [MOD_BITS-1:0] position
);
   import dma_circ_pkg::*;

   localparam int unsigned MINOR_BYTES = MINOR_XFERS * WORD_BYTES;
   localparam int unsigned MAJOR_BYTES = MINOR_BYTES * MAJOR_LOOPS;
   localparam int unsigned BW = $clog2(MINOR_XFERS);
   localparam int unsigned MW = $clog2(MAJOR_LOOPS);

   if (MOD_BITS < 2 || MOD_BITS > 32) begin : g_bad_mod
      $error("dma_circ_src_seq: MOD_BITS out of range");
   end

   logic          active;
   logic          beat_last, minor_last;
   logic          minor_end, major_end;
   logic [BW-1:0] beat_cnt;
   logic [MW-1:0] minor_cnt;

   assign minor_end = active && beat_last;
   assign major_end = minor_end && minor_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         irq    <= 1'b0;
      end else begin
         irq <= major_end;
         if (!active && req) active <= 1'b1;
         else if (minor_end) active <= 1'b0;
      end
   end

   dma_loop_counter #(.LIMIT(MINOR_XFERS)) u_beat (
      .clk(clk), .rst_n(rst_n), .step(active),
      .count(beat_cnt), .last(beat_last));

   dma_loop_counter #(.LIMIT(MAJOR_LOOPS)) u_minor (
      .clk(clk), .rst_n(rst_n), .step(minor_end),
      .count(minor_cnt), .last(minor_last));

   dma_src_offset #(.MOD_BITS(MOD_BITS)) u_src (
      .clk(clk), .rst_n(rst_n), .advance(active),
      .base(src_base), .addr(xfer_src));

   dma_pos_accum #(.MOD_BITS(MOD_BITS), .MAJOR_BYTES(MAJOR_BYTES)) u_pos (
      .clk(clk), .rst_n(rst_n), .add(major_end), .pos(position));

   assign xfer_valid = active;
   assign xfer_dst   = dst_addr;
   assign xfer_size  = SIZE_32BIT;

   assert_src_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !beat_last) |=> (xfer_src == mod_advance($past(xfer_src), MOD_BITS, WORD_BYTES)));
   assert_no_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !beat_last) |=> active);
   assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && beat_last) |=> !active);
   assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   assert_irq_place_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (!active && $past(active)));
endmodule

// File: tb/dma_circ_src_seq_tb.sv
module dma_circ_src_seq_tb;
   localparam int MINOR = 4;
   localparam int MAJOR = 3;
   localparam int MODB  = 6;
   localparam int BUF   = 1 << MODB;
   localparam int MAJ_BYTES = MINOR * 4 * MAJOR;
   localparam logic [31:0] BASE = 32'h8000_0030;
   localparam logic [31:0] DST  = 32'h4003_1020;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic xfer_valid, irq;
   logic [31:0] xfer_src, xfer_dst;
   logic [1:0] xfer_size;
   logic [MODB-1:0] position;

   always #5 clk = ~clk;

   dma_circ_src_seq #(.MINOR_XFERS(MINOR), .MAJOR_LOOPS(MAJOR), .MOD_BITS(MODB)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_base(BASE), .dst_addr(DST), .req(req),
      .xfer_valid(xfer_valid), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
      .xfer_size(xfer_size), .irq(irq), .position(position));

   int total = 0;
   int bad = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit          m_busy = 0, m_irq = 0;
   int          m_beat = 0, m_minor = 0, m_pos = 0;
   int          m_off = 0;
   int          majors = 0, irqs_seen = 0, wraps_seen = 0, joint_wraps = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_irq = 0; m_beat = 0; m_minor = 0; m_pos = 0; m_off = 0;
      end else begin
         m_irq = 0;
         if (m_busy) begin
            m_off = (m_off + 4) % BUF;
            if (m_beat == MINOR - 1) begin
               m_busy = 0; m_beat = 0;
               if (m_minor == MAJOR - 1) begin
                  m_minor = 0; m_irq = 1; majors++;
                  m_pos = m_pos + MAJ_BYTES;
                  if (m_pos >= BUF) m_pos = m_pos - BUF;
               end else m_minor++;
            end else m_beat++;
         end else if (req) begin
            m_busy = 1; m_beat = 0;
         end
      end
   end

   function automatic logic [31:0] exp_src();
      return (BASE & ~32'(BUF - 1)) | ((BASE + 32'(m_off)) & 32'(BUF - 1));
   endfunction

   logic [31:0] prev_src = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         check(xfer_valid == m_busy, "R2/R3/R9 strobe", xfer_valid, m_busy);
         if (m_busy) begin
            check(xfer_src == exp_src(), "R4 source", xfer_src, exp_src());
            check(xfer_dst == DST, "R5 destination", xfer_dst, DST);
            check(xfer_size == 2'b10, "R5 size", xfer_size, 2);
            if (xfer_src[MODB-1:0] < prev_src[MODB-1:0]) wraps_seen++;
            prev_src = xfer_src;
         end
         check(irq == m_irq, "R6 irq", irq, m_irq);
         check(position == MODB'(m_pos), "R8 position", position, m_pos);
         if (irq) begin
            irqs_seen++;
            if (position == 0) joint_wraps++;
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(xfer_valid == 0, "R1 strobe", xfer_valid, 0);
      check(irq == 0, "R1 irq", irq, 0);
      check(position == 0, "R1 position", position, 0);
      check(xfer_src == BASE, "R1 source", xfer_src, BASE);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: single-cycle request
      req = 1'b1; @(negedge clk); req = 1'b0;
      repeat (8) @(negedge clk);
      // R3: request toggling during loops
      for (int i = 0; i < 60; i++) begin req = i[0]; @(negedge clk); end
      // R7/R8: back-to-back held request through several majors
      req = 1'b1;
      repeat (150) @(negedge clk);
      // random request pattern
      for (int i = 0; i < 400; i++) begin req = ($urandom_range(0, 2) != 0); @(negedge clk); end
      req = 1'b0;
      repeat (10) @(negedge clk);
      check(irqs_seen == majors, "R6 irq count", irqs_seen, majors);
      check(majors >= 8, "R7 continued majors", majors, 8);
      check(wraps_seen > 0, "R4 address wrap seen", wraps_seen, 1);
      check(joint_wraps > 0, "R8 position wrap at irq", joint_wraps, 1);
      // R3: idle with no request -> no strobe
      check(xfer_valid == 0, "R2 idle without req", xfer_valid, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule